// File: doc/BRIEF.md
# I2C Register Access Target

This block is a target on a two-wire serial bus that lets a bus host read and write a bank of 128 eight-bit registers held inside it. The clock and data lines are sampled through synchronizer flops in the system clock domain. Start and stop conditions are detected from the synchronized levels, and the block answers only to its own seven-bit device address. The lowest bit of that address comes from a strap input. The data line is open drain: the block never drives it high. It only asserts `sda_oe`, which pulls the line low.

A write transfer carries a pointer byte after the address byte. Bit 7 of the pointer byte enables auto-increment and bits 6:0 select a register. Any data bytes that follow are stored starting at that register. A read transfer has no pointer byte of its own. The host first loads the pointer with a write transfer that it stops right after the pointer byte, then starts a read transfer that returns data from the held index. The surrounding logic sees each register write as a one-cycle strobe with its index and data. It can also read any register at any time through a side read port.

Top module: `i2c_regport`

## Requirements
- R1: The device address is the six bits 100101 followed by the level of `addr_sel`. Bit 0 of the first byte after START is the direction: 0 for a write, 1 for a read. On a matching address the block drives ACK (SDA low during the ninth clock). On any other address it drives neither ACK nor data, and no register changes until the next START or STOP.
- R2: In a write, the byte after the address is the pointer byte. Bit 7 is the auto-increment enable and bits 6:0 are the register index. The block ACKs the pointer byte and every data byte it receives.
- R3: With auto-increment set, successive write data bytes go to successive registers. Each stored byte produces exactly one single-cycle `wr_stb` carrying the index and the data.
- R4: With auto-increment clear, every data byte of a transfer targets the same register, for both writes and reads.
- R5: A read returns data starting at the held pointer index. With auto-increment set, the index advances by one for each byte handed to the host.
- R6: A STOP right after the pointer byte's ACK keeps the new pointer and changes no register.
- R7: In a read, a host ACK requests another byte. A host NO-ACK ends the transfer: the block releases SDA and sends nothing more until the next START.
- R8: A START inside a transfer (repeated START) returns the block to address reception with the bit count cleared. The pointer and its auto-increment flag are kept.
- R9: The index wraps from 127 to 0 when it increments past the top of the bank, for both reads and writes.
- R10: Bytes move MSB first. The block changes its SDA drive only while SCL is low, except when a START or STOP releases it.
- R11: After reset all registers read 0, SDA is released, and the pointer is index 0 with auto-increment clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull the data line low when 1 |
| addr_sel | input | 1 | Strap that sets the low device-address bit |
| wr_stb | output | 1 | One-cycle pulse per stored byte |
| wr_idx | output | 7 | Register index of the stored byte |
| wr_data | output | 8 | Value of the stored byte |
| rd_idx | input | 7 | Side read port index |
| rd_data | output | 8 | Side read port data (combinational) |

## Verification
The hardest state to reach from the ports is a read that begins from a pointer left behind by an earlier, separate transfer. This is a write stopped right after the pointer byte, or a write broken by a repeated START after a data byte has already moved the pointer on. The bench drives these sequences through a bus host that models the wired-AND line and keeps a reference copy of the bank. After each transfer it compares the whole bank through the side read port. It also sweeps all 128 device addresses, checking both the acknowledge and the silence that follows a mismatch.

// File: rtl/i2c_regport.sv
`timescale 1ns/1ps
module i2c_regport #(
  parameter logic [5:0] DEV_HI = 6'b100101,
  parameter int SYNC = 2,
  parameter int DW = 8,
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          addr_sel,
  output logic          wr_stb,
  output logic [IW-1:0] wr_idx,
  output logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  localparam int REGS = 1 << IW;
  localparam int CW = $clog2(DW + 1);

  typedef enum logic [2:0] {P_IDLE, P_ADDR, P_PTR, P_WR, P_RD, P_SKIP} phase_t;

  logic [SYNC-1:0] scl_q, sda_q;
  logic scl_d, sda_d;
  wire scl_s = scl_q[SYNC-1];
  wire sda_s = sda_q[SYNC-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= '1; sda_q <= '1; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC-2:0], scl_i};
      sda_q <= {sda_q[SYNC-2:0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end

  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;
  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;

  phase_t phase;
  logic [CW-1:0] cnt;
  logic ack_slot, ack_drv, host_ack, ptr_inc;
  logic [DW-1:0] sh, tx;
  logic [IW-1:0] ptr;
  logic [DW-1:0] bank [REGS];

  wire byte_done = scl_fall & ~ack_slot & (cnt == CW'(DW));
  wire wr_en = byte_done & (phase == P_WR);
  wire addr_hit = (sh[DW-1:1] == {DEV_HI, addr_sel});

  assign rd_data = bank[rd_idx];
  assign sda_oe = ack_drv | ((phase == P_RD) & ~ack_slot & ~tx[DW-1]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < REGS; i++) bank[i] <= '0;
    end else if (wr_en) begin
      bank[ptr] <= sh;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase <= P_IDLE; cnt <= '0; ack_slot <= 1'b0; ack_drv <= 1'b0;
      host_ack <= 1'b0; sh <= '0; tx <= '1; ptr <= '0; ptr_inc <= 1'b0;
      wr_stb <= 1'b0; wr_idx <= '0; wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_det || stop_det) begin
        phase <= start_det ? P_ADDR : P_IDLE;
        cnt <= '0; ack_slot <= 1'b0; ack_drv <= 1'b0;
      end else if (scl_rise) begin
        if (ack_slot) host_ack <= ~sda_s;
        else begin
          sh <= {sh[DW-2:0], sda_s};
          cnt <= cnt + 1'b1;
        end
      end else if (scl_fall) begin
        if (ack_slot) begin
          ack_slot <= 1'b0; cnt <= '0; ack_drv <= 1'b0;
          if (phase == P_RD) begin
            if (host_ack) begin
              tx <= bank[ptr];
              if (ptr_inc) ptr <= ptr + 1'b1;
            end else phase <= P_SKIP;
          end
        end else if (cnt == CW'(DW)) begin
          ack_slot <= 1'b1;
          case (phase)
            P_ADDR:
              if (addr_hit) begin
                ack_drv <= 1'b1;
                phase <= sh[0] ? P_RD : P_PTR;
              end else phase <= P_SKIP;
            P_PTR: begin
              ptr <= sh[IW-1:0];
              ptr_inc <= sh[DW-1];
              ack_drv <= 1'b1;
              phase <= P_WR;
            end
            P_WR: begin
              wr_stb <= 1'b1; wr_idx <= ptr; wr_data <= sh;
              if (ptr_inc) ptr <= ptr + 1'b1;
              ack_drv <= 1'b1;
            end
            default: ;
          endcase
        end else if (phase == P_RD && cnt != '0) begin
          tx <= {tx[DW-2:0], 1'b1};
        end
      end
    end

  p_skip_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_SKIP || phase == P_IDLE) |-> !sda_oe);
  p_wr_in_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(phase) == P_WR);
  p_stb_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  p_noinc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !ptr_inc) |-> ptr == wr_idx);
  p_inc_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && ptr_inc) |-> ptr == IW'(wr_idx + 1'b1));
  p_start_resets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (phase == P_ADDR && cnt == '0 && $stable(ptr)));
  p_sda_low_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_s) && !$past(start_det || stop_det)) |-> $stable(sda_oe));
endmodule

// File: tb/test_i2c_regport.sv
`timescale 1ns/1ps
module test_i2c_regport;
  localparam int Q = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, host_sda = 1'b1, addr_sel = 1'b1;
  logic sda_oe, wr_stb;
  logic [6:0] wr_idx, rd_idx = '0;
  logic [7:0] wr_data, rd_data;
  wire sda_line = host_sda & ~sda_oe;
  int checks = 0, failures = 0, stb_cnt = 0;
  logic [7:0] model [128];

  always #2.5 clk = ~clk;

  i2c_regport i_i2c_regport (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data));

  always @(posedge clk) if (wr_stb) stb_cnt <= stb_cnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    host_sda = 1'b1; wt(Q); scl = 1'b1; wt(2*Q);
    host_sda = 1'b0; wt(2*Q); scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop;
    scl = 1'b0; host_sda = 1'b0; wt(Q); scl = 1'b1; wt(2*Q);
    host_sda = 1'b1; wt(2*Q);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    host_sda = b; wt(Q); scl = 1'b1; wt(Q); s = sda_line; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); b[i] = s; end
    clk_bit(!ack, s);
  endtask

  task automatic check_bank(input string req);
    for (int i = 0; i < 128; i++) begin
      rd_idx = 7'(i); #1;
      chk(rd_data === model[i], req, rd_data, model[i]);
    end
  endtask

  function automatic logic [7:0] dev(input bit rd);
    return {6'b100101, addr_sel, rd};
  endfunction

  task automatic set_ptr(input logic [7:0] p);
    bit a;
    bus_start; send_byte(dev(1'b0), a); chk(a, "R1 addr ack", a, 1);
    send_byte(p, a); chk(a, "R2 pointer ack", a, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] b;
    int s0;
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    wt(4); rst_n = 1'b1; wt(4);

    chk(sda_oe == 1'b0, "R11 sda released", sda_oe, 0);
    check_bank("R11 reset bank");
    bus_start; send_byte(dev(1'b1), a); recv_byte(1'b0, b); bus_stop;
    chk(b == 8'h00, "R11 reset pointer read", b, 0);

    // R1: sweep all addresses with strap high
    for (int ad = 0; ad < 128; ad++) begin
      bus_start; send_byte({7'(ad), 1'b0}, a);
      chk(a == (ad == 7'h4B), "R1 address sweep", a, ad == 7'h4B);
      if (ad != 7'h4B) begin
        send_byte(8'h00, a); chk(!a, "R1 silent after mismatch", a, 0);
        send_byte(8'h5A, a); chk(!a, "R1 silent data", a, 0);
      end
      bus_stop;
    end
    check_bank("R1 no write on mismatch");
    addr_sel = 1'b0;
    bus_start; send_byte(8'h94, a); chk(a, "R1 strap low match", a, 1); bus_stop;
    bus_start; send_byte(8'h96, a); chk(!a, "R1 strap low mismatch", a, 0); bus_stop;
    addr_sel = 1'b1;

    // R3: auto-increment write
    s0 = stb_cnt;
    set_ptr(8'h8A);
    for (int k = 0; k < 5; k++) begin
      b = 8'(k * 37 + 3);
      send_byte(b, a); chk(a, "R2 data ack", a, 1);
      model[10 + k] = b;
    end
    bus_stop;
    check_bank("R3 consecutive write");
    chk(stb_cnt - s0 == 5, "R3 strobe count", stb_cnt - s0, 5);

    // R4: fixed index write
    set_ptr(8'h14);
    for (int k = 0; k < 3; k++) begin
      b = 8'(8'hC0 + k); send_byte(b, a); model[20] = b;
    end
    bus_stop;
    check_bank("R4 same register write");

    // R9: write wrap
    set_ptr(8'hFE);
    for (int k = 0; k < 4; k++) begin
      b = 8'(8'h70 + k); send_byte(b, a); model[(126 + k) % 128] = b;
    end
    bus_stop;
    check_bank("R9 write wrap");

    // R6 + R5: aborted write then incrementing read
    set_ptr(8'h8A); bus_stop;
    check_bank("R6 abort no write");
    bus_start; send_byte(dev(1'b1), a); chk(a, "R1 read addr ack", a, 1);
    for (int k = 0; k < 5; k++) begin
      recv_byte(k != 4, b);
      chk(b == model[10 + k], "R5 read sequence", b, model[10 + k]);
    end
    // R7: after NO-ACK nothing is driven
    wt(2);
    chk(sda_oe == 1'b0, "R7 release after nack", sda_oe, 0);
    recv_byte(1'b0, b);
    chk(b == 8'hFF, "R7 no further data", b, 8'hFF);
    bus_stop;
    bus_start; send_byte(dev(1'b1), a); recv_byte(1'b0, b); bus_stop;
    chk(b == model[15], "R5 pointer advanced", b, model[15]);

    // R4: fixed index read
    set_ptr(8'h14); bus_stop;
    bus_start; send_byte(dev(1'b1), a);
    for (int k = 0; k < 3; k++) begin
      recv_byte(k != 2, b); chk(b == model[20], "R4 same register read", b, model[20]);
    end
    bus_stop;

    // R9: read wrap
    set_ptr(8'hFF); bus_stop;
    bus_start; send_byte(dev(1'b1), a);
    recv_byte(1'b1, b); chk(b == model[127], "R9 read top", b, model[127]);
    recv_byte(1'b0, b); chk(b == model[0], "R9 read wrap", b, model[0]);
    bus_stop;

    // R8: repeated START keeps the advanced pointer
    set_ptr(8'hA8);
    send_byte(8'hAA, a); model[40] = 8'hAA;
    bus_start; send_byte(dev(1'b1), a); chk(a, "R8 addr after restart", a, 1);
    recv_byte(1'b0, b); bus_stop;
    chk(b == model[41], "R8 pointer kept", b, model[41]);
    set_ptr(8'h32);
    bus_start; send_byte(dev(1'b0), a); chk(a, "R8 restart write addr", a, 1);
    send_byte(8'h05, a); bus_stop;
    check_bank("R8 restart treats next byte as pointer");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule